// File: doc/BRIEF.md
# Request tag filter

This block sits in front of an event counter in a cache monitoring unit. It decides whether each incoming cache request should raise a qualified event strobe. Each request carries a 3-bit request type, a 14-bit source identifier, a 2-bit ring channel and the 8-bit code of the event that the counter is watching. Three configuration registers, written through a simple word write port, steer the decision:

- The tag control register turns request-type tagging on and picks the request type to tag.
- The source register holds the source identifier to compare against.
- The channel register selects a ring channel.

Request-type tagging can only ever tag reads. A source comparison only takes effect while read tagging is active. The channel selection only applies to a fixed window of event codes. The qualified strobe and a "request was tagged" flag are registered, so they appear one clock after the request.

Top module: `rtag_filter`

## Requirements
- R1: After reset all three registers are zero and both outputs are low. With every filter off, each valid request raises `evtHit` one cycle later, whatever its type, source, channel or code.
- R2: `evtHit` and `reqTagged` are high in the cycle after a clock edge only when `reqValid` was high at that edge. A cycle without a valid request gives low outputs.
- R3: Type tagging is active only when bit 0 (mark enable) and bit 2 (request enable) of the tag control register are both set. If either bit is clear, `reqTagged` stays low and every valid request passes, subject to the channel rule.
- R4: When type tagging is active and bits [9:7] hold 4 (the read code), a valid request with `reqType` = 4 passes and sets `reqTagged`. A request of any other type does not pass.
- R5: When type tagging is active and bits [9:7] hold any value other than 4, no request is tagged and none passes.
- R6: When type tagging is active and bit 3 (source enable) is set, a read passes and is tagged only if `reqSrc` equals bits [14:1] of the source register.
- R7: Bit 3 has no effect while type tagging is inactive. Requests pass regardless of their source.
- R8: When bits [1:0] of the channel register are non-zero, a request whose `reqCode` lies in 0x47 to 0x59 inclusive passes only if `reqChan` equals that value. Codes outside the window are not filtered by channel.
- R9: A channel register value of 0 disables channel filtering for every code.
- R10: A register write takes effect for requests presented from the next clock edge on. A write to an address other than the three register addresses changes no filtering behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 16 | Register byte address (tag control 0x1b2c, source 0x1b40, channel 0x1c00) |
| cfgWdata | input | 32 | Register write data |
| reqValid | input | 1 | Request present this cycle |
| reqType | input | 3 | Request type, 4 = read |
| reqSrc | input | 14 | Source identifier of the request |
| reqChan | input | 2 | Ring channel of the request |
| reqCode | input | 8 | Event code being counted |
| evtHit | output | 1 | Qualified event strobe, one cycle after the request |
| reqTagged | output | 1 | Request was tagged by the type/source filter, one cycle after the request |

## Verification
The bench drives event codes 0x46, 0x47, 0x59 and 0x5a against a non-zero channel selection. A design with an off-by-one window would filter a neighbour code or let an edge code through. It enables the source bit without read tagging, where a design that failed to gate the source match would drop requests from other sources. It programs a non-read type with tagging on, where a careless design would count every request as untagged. It also writes to a stray address, which a loose decoder would take as a register write.

// File: rtl/rtag_pkg.sv
package rtag_pkg;
  localparam int TYPE_W = 3;
  localparam int SRC_W  = 14;
  localparam int CHAN_W = 2;
  localparam int CODE_W = 8;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  // field positions inside the tag control register
  localparam int MARK_BIT    = 0;
  localparam int REQEN_BIT   = 2;
  localparam int SRCEN_BIT   = 3;
  localparam int TYPE_LO_BIT = 7;
  // field position inside the source register
  localparam int SRC_LO_BIT  = 1;

  localparam logic [TYPE_W-1:0] READ_CODE = 3'd4;

  // strobes and fields handed from control to datapath
  typedef struct packed {
    logic              typeGate;
    logic [TYPE_W-1:0] typeSel;
    logic              srcOn;
    logic [SRC_W-1:0]  srcId;
    logic [CHAN_W-1:0] chanSel;
  } filtCfg_t;
endpackage

// File: rtl/rtag_cfg_regs.sv
module rtag_cfg_regs
  import rtag_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h1b2c,
  parameter logic [ADDR_W-1:0] SRC_ADDR  = 16'h1b40,
  parameter logic [ADDR_W-1:0] CHAN_ADDR = 16'h1c00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  output filtCfg_t          cfg
);
  localparam int TYPE_HI_BIT = TYPE_LO_BIT + TYPE_W - 1;
  localparam int SRC_HI_BIT  = SRC_LO_BIT + SRC_W - 1;

  logic              markEn, reqEnBit, srcEnBit;
  logic [TYPE_W-1:0] typeField;
  logic [SRC_W-1:0]  srcField;
  logic [CHAN_W-1:0] chanField;

  logic hitCtrl, hitSrc, hitChan;
  assign hitCtrl = cfgWe && (cfgAddr == CTRL_ADDR);
  assign hitSrc  = cfgWe && (cfgAddr == SRC_ADDR);
  assign hitChan = cfgWe && (cfgAddr == CHAN_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      markEn    <= 1'b0;
      reqEnBit  <= 1'b0;
      srcEnBit  <= 1'b0;
      typeField <= '0;
      srcField  <= '0;
      chanField <= '0;
    end else begin
      if (hitCtrl) begin
        markEn    <= cfgWdata[MARK_BIT];
        reqEnBit  <= cfgWdata[REQEN_BIT];
        srcEnBit  <= cfgWdata[SRCEN_BIT];
        typeField <= cfgWdata[TYPE_HI_BIT:TYPE_LO_BIT];
      end
      if (hitSrc)  srcField  <= cfgWdata[SRC_HI_BIT:SRC_LO_BIT];
      if (hitChan) chanField <= cfgWdata[CHAN_W-1:0];
    end
  end

  logic unusedWdata;
  assign unusedWdata = ^{cfgWdata[DATA_W-1:TYPE_HI_BIT+1], cfgWdata[1]};

  always_comb begin
    cfg.typeGate = markEn && reqEnBit;
    cfg.typeSel  = typeField;
    // source compare only takes effect under active type tagging
    cfg.srcOn    = srcEnBit && markEn && reqEnBit;
    cfg.srcId    = srcField;
    cfg.chanSel  = chanField;
  end

  // R10
  stray_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && !hitCtrl && !hitSrc && !hitChan) |=> $stable(cfg));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !$past(rstN) |-> (cfg == '0 || rstN));
endmodule

// File: rtl/rtag_match.sv
module rtag_match
  import rtag_pkg::*;
#(
  parameter logic [CODE_W-1:0] CHAN_CODE_LO = 8'h47,
  parameter logic [CODE_W-1:0] CHAN_CODE_HI = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  filtCfg_t          cfg,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [CODE_W-1:0] reqCode,
  output logic              evtHit,
  output logic              reqTagged
);
  logic isRead, typeOk, srcOk, tagMatch, inWindow, chanOk;

  always_comb begin
    isRead   = (reqType == READ_CODE);
    typeOk   = isRead && (cfg.typeSel == READ_CODE);
    srcOk    = !cfg.srcOn || (reqSrc == cfg.srcId);
    tagMatch = typeOk && srcOk;
    inWindow = (reqCode >= CHAN_CODE_LO) && (reqCode <= CHAN_CODE_HI);
    chanOk   = (cfg.chanSel == '0) || !inWindow || (reqChan == cfg.chanSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtHit    <= 1'b0;
      reqTagged <= 1'b0;
    end else begin
      evtHit    <= reqValid && (!cfg.typeGate || tagMatch) && chanOk;
      reqTagged <= reqValid && cfg.typeGate && tagMatch;
    end
  end

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtHit || reqTagged) |-> $past(reqValid));

  // R4
  tag_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqTagged |-> ($past(reqType) == READ_CODE && $past(cfg.typeSel) == READ_CODE));

  // R6
  src_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqTagged && $past(cfg.srcOn)) |-> ($past(reqSrc) == $past(cfg.srcId)));

  // R8
  chan_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtHit && $past(cfg.chanSel) != '0 && $past(reqCode) >= CHAN_CODE_LO
     && $past(reqCode) <= CHAN_CODE_HI) |-> ($past(reqChan) == $past(cfg.chanSel)));

  // R3
  untagged_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqTagged |-> (evtHit || $past(cfg.chanSel) != '0));
endmodule

// File: rtl/rtag_filter.sv
module rtag_filter
  import rtag_pkg::*;
#(
  parameter logic [ADDR_W-1:0] CTRL_ADDR    = 16'h1b2c,
  parameter logic [ADDR_W-1:0] SRC_ADDR     = 16'h1b40,
  parameter logic [ADDR_W-1:0] CHAN_ADDR    = 16'h1c00,
  parameter logic [CODE_W-1:0] CHAN_CODE_LO = 8'h47,
  parameter logic [CODE_W-1:0] CHAN_CODE_HI = 8'h59
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              reqValid,
  input  logic [TYPE_W-1:0] reqType,
  input  logic [SRC_W-1:0]  reqSrc,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic [CODE_W-1:0] reqCode,
  output logic              evtHit,
  output logic              reqTagged
);
  filtCfg_t cfg;

  rtag_cfg_regs #(
    .CTRL_ADDR(CTRL_ADDR),
    .SRC_ADDR (SRC_ADDR),
    .CHAN_ADDR(CHAN_ADDR)
  ) uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgWdata(cfgWdata),
    .cfg     (cfg)
  );

  rtag_match #(
    .CHAN_CODE_LO(CHAN_CODE_LO),
    .CHAN_CODE_HI(CHAN_CODE_HI)
  ) uMatch (
    .clk      (clk),
    .rstN     (rstN),
    .cfg      (cfg),
    .reqValid (reqValid),
    .reqType  (reqType),
    .reqSrc   (reqSrc),
    .reqChan  (reqChan),
    .reqCode  (reqCode),
    .evtHit   (evtHit),
    .reqTagged(reqTagged)
  );
endmodule

// File: tb/tb_rtag_filter.sv
module tb_rtag_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [15:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqType = '0;
  logic [13:0] reqSrc = '0;
  logic [1:0]  reqChan = '0;
  logic [7:0]  reqCode = '0;
  logic        evtHit, reqTagged;

  rtag_filter dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int    checks = 0;
  int    failures = 0;
  int    cycles = 0;
  bit    checking = 1'b0;
  bit    done = 1'b0;
  string curReq = "R1";
  string expReq = "R1";

  // behavioural reference state
  logic [31:0] mCtrl, mSrc, mChan;
  bit expHit, expTag;

  always @(posedge clk) begin
    bit gate, srcOn, match, inWin, chanOk;
    if (!rstN) begin
      mCtrl = 0; mSrc = 0; mChan = 0;
      expHit = 0; expTag = 0;
    end else begin
      gate   = mCtrl[0] & mCtrl[2];
      srcOn  = mCtrl[3] & gate;
      match  = (reqType == 3'd4) && (mCtrl[9:7] == 3'd4) &&
               (!srcOn || reqSrc == mSrc[14:1]);
      inWin  = (reqCode >= 8'h47) && (reqCode <= 8'h59);
      chanOk = (mChan[1:0] == 2'd0) || !inWin || (reqChan == mChan[1:0]);
      expTag = reqValid && gate && match;
      expHit = reqValid && (!gate || match) && chanOk;
      if (cfgWe) begin
        if (cfgAddr == 16'h1b2c) mCtrl = cfgWdata;
        else if (cfgAddr == 16'h1b40) mSrc = cfgWdata;
        else if (cfgAddr == 16'h1c00) mChan = cfgWdata;
      end
    end
    expReq = curReq;
  end

  always @(negedge clk) begin
    if (checking && rstN && !done) begin
      checks++;
      if (evtHit !== expHit || reqTagged !== expTag) begin
        failures++;
        $display("FAIL %s: evtHit=%0b exp %0b, reqTagged=%0b exp %0b",
                 expReq, evtHit, expHit, reqTagged, expTag);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: cycles=%0d exp below 100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    cyc();
    cfgWe = 1'b0;
  endtask

  task automatic rq(input bit v, input logic [2:0] t, input logic [13:0] s,
                    input logic [1:0] c, input logic [7:0] code);
    reqValid = v; reqType = t; reqSrc = s; reqChan = c; reqCode = code;
    cyc();
    reqValid = 1'b0;
  endtask

  localparam logic [31:0] TAG_READ = 32'h5 | (32'd4 << 7);

  initial begin
    repeat (3) cyc();
    // R1: reset state of outputs
    checks++;
    if (evtHit !== 1'b0 || reqTagged !== 1'b0) begin
      failures++;
      $display("FAIL R1: evtHit=%0b reqTagged=%0b exp 0 0", evtHit, reqTagged);
    end
    rstN = 1'b1;
    checking = 1'b1;
    cyc();

    curReq = "R1";  // all filters off after reset
    rq(1, 3'd1, 14'h0011, 2'd3, 8'h50);
    rq(1, 3'd4, 14'h3fff, 2'd0, 8'h47);
    curReq = "R2";
    rq(0, 3'd4, 14'h0, 2'd0, 8'h10);
    rq(1, 3'd2, 14'h0, 2'd0, 8'h10);
    rq(0, 3'd2, 14'h0, 2'd0, 8'h10);

    curReq = "R3";  // mark enable only, request enable clear
    wr(16'h1b2c, 32'h1 | (32'd4 << 7));
    rq(1, 3'd1, 14'h5, 2'd0, 8'h20);
    rq(1, 3'd4, 14'h5, 2'd0, 8'h20);
    wr(16'h1b2c, 32'h4 | (32'd4 << 7));
    rq(1, 3'd6, 14'h5, 2'd0, 8'h20);

    curReq = "R4";
    wr(16'h1b2c, TAG_READ);
    rq(1, 3'd4, 14'h7, 2'd1, 8'h30);
    rq(1, 3'd2, 14'h7, 2'd1, 8'h30);
    rq(1, 3'd5, 14'h7, 2'd1, 8'h30);

    curReq = "R5";
    wr(16'h1b2c, 32'h5 | (32'd3 << 7));
    rq(1, 3'd4, 14'h7, 2'd0, 8'h30);
    rq(1, 3'd3, 14'h7, 2'd0, 8'h30);

    curReq = "R6";
    wr(16'h1b40, 32'(14'h1234) << 1);
    wr(16'h1b2c, TAG_READ | 32'h8);
    rq(1, 3'd4, 14'h1234, 2'd0, 8'h30);
    rq(1, 3'd4, 14'h1235, 2'd0, 8'h30);
    rq(1, 3'd1, 14'h1234, 2'd0, 8'h30);

    curReq = "R7";
    wr(16'h1b2c, 32'h8 | (32'd4 << 7));
    rq(1, 3'd4, 14'h0001, 2'd0, 8'h30);
    rq(1, 3'd0, 14'h2222, 2'd0, 8'h30);

    curReq = "R8";
    wr(16'h1b2c, 32'h0);
    wr(16'h1c00, 32'h2);
    rq(1, 3'd1, 14'h0, 2'd1, 8'h46);
    rq(1, 3'd1, 14'h0, 2'd1, 8'h47);
    rq(1, 3'd1, 14'h0, 2'd2, 8'h47);
    rq(1, 3'd1, 14'h0, 2'd1, 8'h59);
    rq(1, 3'd1, 14'h0, 2'd2, 8'h59);
    rq(1, 3'd1, 14'h0, 2'd1, 8'h5a);

    curReq = "R9";
    wr(16'h1c00, 32'h0);
    rq(1, 3'd1, 14'h0, 2'd1, 8'h47);
    rq(1, 3'd1, 14'h0, 2'd3, 8'h50);

    curReq = "R10";
    wr(16'h1b2c, TAG_READ);
    wr(16'h1b30, 32'h0);
    wr(16'h1c04, 32'h3);
    rq(1, 3'd2, 14'h0, 2'd1, 8'h50);
    rq(1, 3'd4, 14'h0, 2'd1, 8'h50);
    // write and request in the same cycle: old config applies
    cfgWe = 1'b1; cfgAddr = 16'h1b2c; cfgWdata = 32'h0;
    rq(1, 3'd2, 14'h0, 2'd0, 8'h10);
    cfgWe = 1'b0;
    rq(1, 3'd2, 14'h0, 2'd0, 8'h10);

    curReq = "R2";  // mixed traffic with random reconfiguration
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) begin
        case ($urandom_range(0, 3))
          0: cfgAddr = 16'h1b2c;
          1: cfgAddr = 16'h1b40;
          2: cfgAddr = 16'h1c00;
          default: cfgAddr = 16'h1b44;
        endcase
        cfgWe = 1'b1;
        cfgWdata = $urandom();
        if (cfgAddr == 16'h1b2c && $urandom_range(0, 1) == 1)
          cfgWdata[9:7] = 3'd4;
        if (cfgAddr == 16'h1b40) cfgWdata[14:1] = 14'($urandom_range(0, 3));
      end else begin
        cfgWe = 1'b0;
      end
      reqValid = $urandom_range(0, 3) != 0;
      reqType  = $urandom_range(0, 1) == 1 ? 3'd4 : 3'($urandom());
      reqSrc   = 14'($urandom_range(0, 3));
      reqChan  = 2'($urandom());
      reqCode  = 8'($urandom_range(8'h40, 8'h60));
      cyc();
    end
    cfgWe = 1'b0;
    reqValid = 1'b0;
    cyc();
    cyc();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule